// File: doc/BRIEF.md
# Cascaded Prescaled Tick Timer

The block holds three 16-bit down-counters behind one byte-wide register port. The third counter is a prescaler. It counts a master clock enable, and each of its terminal pulses advances the other two counters by one. Counter 0 makes a periodic tick interrupt. Counter 1 usually runs as a free-running timebase.

Software sets up a counter with a control byte that selects the counter, the access kind and the counting mode. It then writes the 16-bit start value as two data bytes, low byte first. A latch command freezes a counter's value so that two byte reads return one consistent value. The terminal pulses of counters 0 and 1 set sticky interrupt flags. Software clears a flag by writing a mask to a clear register.

The port is a plain register interface, not a stream, so it has no back-pressure. A write takes effect at the clock edge where `wr_en` is high. Read data is combinational from `addr`, and the read pointer advances at each edge where `rd_en` is high.

Top module: `cascade_tick_timer`

## Requirements
- R1: After reset both interrupt outputs are 0 and all counters are stopped with value 0, so a live data read returns 0x00.
- R2: Addresses 0, 1 and 2 are the data ports of counters 0, 1 and 2. A counter starts only once the second data byte (the high byte) of its load has been written after a load command. A low byte written alone leaves the counter stopped.
- R3: Counter 2 decrements on each cycle with `tick_en` high. Counters 0 and 1 decrement only on cycles where counter 2 gives a terminal pulse. With counter 2 loaded with 8 and counter 0 loaded with 3, the counter 0 flag sets on the 24th enable.
- R4: In rate mode (control bits 3:1 = 010), a counter loaded with N pulses on the enable where its value is 1, and reloads N on that same enable, so it pulses every N enables. A load value of 0 counts as 65536: one enable after loading 0 leaves the value 0xFFFF.
- R5: The control byte is sel in bits 7:6, access in bits 5:4 and mode in bits 3:1. A control write with a nonzero access field stops the selected counter until a full two-byte load completes. In strobe mode (bits 3:1 = 100), a loaded counter pulses once after N enables, then stays stopped at 0.
- R6: A control write with access 00 latches the selected counter's value. The next two reads of that counter return the low byte and then the high byte of the latched value, even if the counter keeps counting. Reads after that return the live value.
- R7: A write to address 4 clears the counter 0 flag if bit 0 is set and the counter 1 flag if bit 1 is set. Writing 0x03 clears both. Other bits have no effect.
- R8: If a clear and a terminal pulse reach the same flag in the same cycle, the flag stays set.
- R9: A flag stays set until it is cleared. The flag is set one clock edge after the enabling cycle of its counter's terminal pulse.
- R10: With counter 1 loaded with 0xFFFF in rate mode, 0xFFFF minus its latched value equals the number of terminal pulses counter 2 has given since the load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Master clock enable into the prescaler |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Data read strobe; advances the byte pointer |
| addr | input | 3 | 0-2 counter data, 3 control, 4 interrupt clear |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte of the addressed counter |
| irq_tick | output | 1 | Counter 0 sticky interrupt flag |
| irq_base | output | 1 | Counter 1 sticky interrupt flag |

## Verification
A flag output changes at the edge that ends the enable cycle in which the prescaler and the counter both reach 1. The bench therefore drives enables one per clock, samples the flags one time unit after the last enable's edge, and checks first one enable short of the threshold, then exactly at it. Read data is combinational, so the bench samples it within the cycle where `rd_en` is high. A load or latch is in place after the edge of its write. The bench latches only with `tick_en` low so that the frozen value is exact.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int BYTE_W = 8;

  typedef logic [2:0] mode_t;
  localparam mode_t MODE_RATE   = 3'b010;
  localparam mode_t MODE_STROBE = 3'b100;

  // control byte layout: sel[7:6] access[5:4] mode[3:1]
  function automatic logic [1:0] ctl_sel(input logic [BYTE_W-1:0] b);
    return b[7:6];
  endfunction

  function automatic logic [1:0] ctl_acc(input logic [BYTE_W-1:0] b);
    return b[5:4];
  endfunction

  function automatic mode_t ctl_mode(input logic [BYTE_W-1:0] b);
    return b[3:1];
  endfunction
endpackage

// File: rtl/timer_channel.sv
module timer_channel
  import tick_timer_pkg::*;
#(
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          ctl_we,
  input  logic [1:0]    ctl_acc_i,
  input  mode_t         ctl_mode_i,
  input  logic          dat_we,
  input  logic [BW-1:0] dat_wd,
  input  logic          dat_re,
  output logic [BW-1:0] dat_rd,
  output logic          tc
);
  localparam int CW = 2 * BW;

  logic [CW-1:0] count, reload, hold_val;
  logic [BW-1:0] lo_hold;
  logic          is_rate, armed, wr_hi, latched, rd_hi;
  logic          load_cmd, at_one;
  logic [CW-1:0] src;

  assign load_cmd = ctl_we && (ctl_acc_i != 2'b00);
  assign at_one   = (count == CW'(1));
  assign tc       = en && armed && at_one;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      reload  <= '0;
      lo_hold <= '0;
      is_rate <= 1'b0;
      armed   <= 1'b0;
      wr_hi   <= 1'b0;
    end else if (load_cmd) begin
      is_rate <= (ctl_mode_i == MODE_RATE);
      armed   <= 1'b0;
      wr_hi   <= 1'b0;
    end else if (dat_we) begin
      if (!wr_hi) begin
        lo_hold <= dat_wd;
        wr_hi   <= 1'b1;
      end else begin
        count   <= {dat_wd, lo_hold};
        reload  <= {dat_wd, lo_hold};
        armed   <= 1'b1;
        wr_hi   <= 1'b0;
      end
    end else if (en && armed) begin
      if (at_one) begin
        if (is_rate) begin
          count <= reload;
        end else begin
          count <= '0;
          armed <= 1'b0;
        end
      end else begin
        count <= count - CW'(1);
      end
    end
  end

  // coherent two-byte read path
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latched  <= 1'b0;
      hold_val <= '0;
      rd_hi    <= 1'b0;
    end else if (ctl_we && !load_cmd && !latched) begin
      latched  <= 1'b1;
      hold_val <= count;
      rd_hi    <= 1'b0;
    end else if (dat_re) begin
      if (rd_hi) begin
        rd_hi   <= 1'b0;
        latched <= 1'b0;
      end else begin
        rd_hi   <= 1'b1;
      end
    end
  end

  assign src    = latched ? hold_val : count;
  assign dat_rd = rd_hi ? src[CW-1:BW] : src[BW-1:0];
endmodule

// File: rtl/irq_flag.sv
module irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= set_i | (q & ~clr_i);
  end
endmodule

// File: rtl/cascade_tick_timer.sv
module cascade_tick_timer
  import tick_timer_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int CTL_ADDR = 3,
  parameter int CLR_ADDR = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data,
  output logic              irq_tick,
  output logic              irq_base
);
  localparam int NUM_CH = 3;
  localparam int PRE_CH = NUM_CH - 1;
  localparam int NUM_IRQ = NUM_CH - 1;

  logic              ctl_hit, clr_hit, pre_tc;
  logic [NUM_IRQ-1:0] ch_tc, flags;
  logic [BYTE_W-1:0] rd_byte [NUM_CH];

  assign ctl_hit = wr_en && (addr == ADDR_W'(CTL_ADDR));
  assign clr_hit = wr_en && (addr == ADDR_W'(CLR_ADDR));

  timer_channel #(.BW(BYTE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(tick_en),
    .ctl_we(ctl_hit && (ctl_sel(wr_data) == 2'(PRE_CH))),
    .ctl_acc_i(ctl_acc(wr_data)), .ctl_mode_i(ctl_mode(wr_data)),
    .dat_we(wr_en && (addr == ADDR_W'(PRE_CH))), .dat_wd(wr_data),
    .dat_re(rd_en && (addr == ADDR_W'(PRE_CH))),
    .dat_rd(rd_byte[PRE_CH]), .tc(pre_tc)
  );

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_ch
    timer_channel #(.BW(BYTE_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .en(pre_tc),
      .ctl_we(ctl_hit && (ctl_sel(wr_data) == 2'(i))),
      .ctl_acc_i(ctl_acc(wr_data)), .ctl_mode_i(ctl_mode(wr_data)),
      .dat_we(wr_en && (addr == ADDR_W'(i))), .dat_wd(wr_data),
      .dat_re(rd_en && (addr == ADDR_W'(i))),
      .dat_rd(rd_byte[i]), .tc(ch_tc[i])
    );

    irq_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set_i(ch_tc[i]),
      .clr_i(clr_hit && wr_data[i]), .q(flags[i])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (addr == ADDR_W'(i)) rd_data = rd_byte[i];
  end

  assign irq_tick = flags[0];
  assign irq_base = flags[1];
endmodule

// File: rtl/tick_timer_checker.sv
module tick_timer_checker #(
  parameter int ADDR_W   = 3,
  parameter int CLR_ADDR = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wr_data,
  input logic              irq_tick,
  input logic              irq_base,
  input logic              pre_tc,
  input logic [1:0]        ch_tc
);
  logic clr0, clr1;
  assign clr0 = wr_en && (addr == ADDR_W'(CLR_ADDR)) && wr_data[0];
  assign clr1 = wr_en && (addr == ADDR_W'(CLR_ADDR)) && wr_data[1];

  a_r3_pre_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    pre_tc |-> tick_en);
  a_r3_cascade: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_tc != 2'b00) |-> pre_tc);
  a_r9_tick_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_tick && !clr0) |=> irq_tick);
  a_r9_base_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_base && !clr1) |=> irq_base);
  a_r7_tick_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr0 && !ch_tc[0]) |=> !irq_tick);
  a_r7_base_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr1 && !ch_tc[1]) |=> !irq_base);
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ch_tc[0] |=> irq_tick);
  a_r9_base_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_base) |-> $past(ch_tc[1]));
endmodule

bind cascade_tick_timer tick_timer_checker #(.ADDR_W(ADDR_W), .CLR_ADDR(CLR_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .addr(addr),
  .wr_data(wr_data), .irq_tick(irq_tick), .irq_base(irq_base),
  .pre_tc(pre_tc), .ch_tc(ch_tc)
);

// File: tb/cascade_tick_timer_test.sv
`timescale 1ns/1ps
module cascade_tick_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq_tick, irq_base;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  cascade_tick_timer uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .irq_tick(irq_tick), .irq_base(irq_base)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rd_data;
    @(posedge clk); #1 rd_en = 1'b0;
  endtask

  task automatic load(input logic [2:0] ch, input logic [7:0] ctl, input logic [15:0] v);
    bus_wr(3'd3, ctl); bus_wr(ch, v[7:0]); bus_wr(ch, v[15:8]);
  endtask

  task automatic read16(input logic [2:0] ch, input bit do_latch, output logic [15:0] v);
    logic [7:0] lo, hi;
    if (do_latch) bus_wr(3'd3, {ch[1:0], 6'b000000});
    bus_rd(ch, lo); bus_rd(ch, hi);
    v = {hi, lo};
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(posedge clk); #1 tick_en = 1'b0;
    end
  endtask

  task automatic t_reset_state();
    logic [15:0] v;
    do_reset();
    check(irq_tick == 1'b0, "R1 irq_tick after reset", irq_tick, 0);
    check(irq_base == 1'b0, "R1 irq_base after reset", irq_base, 0);
    read16(3'd0, 1'b0, v);
    check(v == 16'h0000, "R1 live read after reset", v, 0);
  endtask

  task automatic t_load_order();
    do_reset();
    load(3'd2, 8'hB4, 16'd2);
    bus_wr(3'd3, 8'h34);
    bus_wr(3'd0, 8'h02);
    ticks(20);
    check(irq_tick == 1'b0, "R2 low byte alone keeps counter stopped", irq_tick, 0);
    bus_wr(3'd0, 8'h00);
    ticks(4);
    check(irq_tick == 1'b1, "R2 runs after high byte", irq_tick, 1);
  endtask

  task automatic t_cascade();
    do_reset();
    load(3'd0, 8'h34, 16'd3);
    load(3'd2, 8'hB4, 16'd8);
    ticks(23);
    check(irq_tick == 1'b0, "R3 no flag before 24th enable", irq_tick, 0);
    ticks(1);
    check(irq_tick == 1'b1, "R3 flag on 24th enable", irq_tick, 1);
    ticks(30);
    check(irq_tick == 1'b1, "R9 flag held without clear", irq_tick, 1);
    check(irq_base == 1'b0, "R3 unloaded counter 1 silent", irq_base, 0);
  endtask

  task automatic t_clear_bits();
    do_reset();
    load(3'd0, 8'h34, 16'd2);
    load(3'd1, 8'h74, 16'd2);
    load(3'd2, 8'hB4, 16'd2);
    ticks(4);
    check(irq_tick && irq_base, "R7 both flags set", {irq_tick, irq_base}, 3);
    bus_wr(3'd4, 8'h02);
    check(!irq_base && irq_tick, "R7 bit1 clears only base", {irq_tick, irq_base}, 2);
    bus_wr(3'd4, 8'hFC);
    check(irq_tick == 1'b1, "R7 other bits ignored", irq_tick, 1);
    bus_wr(3'd4, 8'h01);
    check(irq_tick == 1'b0, "R7 bit0 clears tick", irq_tick, 0);
    ticks(4);
    bus_wr(3'd4, 8'h03);
    check(!irq_tick && !irq_base, "R7 0x03 clears both", {irq_tick, irq_base}, 0);
  endtask

  task automatic t_set_wins();
    do_reset();
    load(3'd0, 8'h34, 16'd2);
    load(3'd2, 8'hB4, 16'd2);
    ticks(4);
    ticks(3);
    @(negedge clk); tick_en = 1'b1; addr = 3'd4; wr_data = 8'h01; wr_en = 1'b1;
    @(posedge clk); #1 tick_en = 1'b0; wr_en = 1'b0;
    check(irq_tick == 1'b1, "R8 pulse beats clear", irq_tick, 1);
    bus_wr(3'd4, 8'h01);
    check(irq_tick == 1'b0, "R8 plain clear afterwards", irq_tick, 0);
  endtask

  task automatic t_rate_zero();
    logic [15:0] v;
    do_reset();
    load(3'd2, 8'hB4, 16'h0000);
    ticks(1);
    read16(3'd2, 1'b1, v);
    check(v == 16'hFFFF, "R4 zero load is 65536", v, 16'hFFFF);
    load(3'd0, 8'h34, 16'd2);
    load(3'd2, 8'hB4, 16'd3);
    ticks(5);
    check(irq_tick == 1'b0, "R4 before first period", irq_tick, 0);
    ticks(1);
    check(irq_tick == 1'b1, "R4 first period", irq_tick, 1);
    bus_wr(3'd4, 8'h01);
    ticks(5);
    check(irq_tick == 1'b0, "R4 reload not early", irq_tick, 0);
    ticks(1);
    check(irq_tick == 1'b1, "R4 reload period", irq_tick, 1);
  endtask

  task automatic t_strobe_halt();
    logic [15:0] v;
    do_reset();
    load(3'd0, 8'h38, 16'd2);
    load(3'd1, 8'h74, 16'd2);
    load(3'd2, 8'hB4, 16'd2);
    ticks(3);
    check(irq_tick == 1'b0, "R5 strobe not yet", irq_tick, 0);
    ticks(1);
    check(irq_tick && irq_base, "R5 strobe and rate fire", {irq_tick, irq_base}, 3);
    bus_wr(3'd4, 8'h03);
    bus_wr(3'd3, 8'h74);
    ticks(20);
    check(irq_tick == 1'b0, "R5 strobe fires once", irq_tick, 0);
    check(irq_base == 1'b0, "R5 control write stops counter", irq_base, 0);
    read16(3'd0, 1'b1, v);
    check(v == 16'h0000, "R5 strobe rests at zero", v, 0);
  endtask

  task automatic t_latch_base();
    logic [15:0] v;
    do_reset();
    load(3'd1, 8'h74, 16'hFFFF);
    load(3'd2, 8'hB4, 16'd2);
    ticks(10);
    read16(3'd1, 1'b1, v);
    check(16'hFFFF - v == 16'd5, "R10 elapsed from timebase", 16'hFFFF - v, 5);
    bus_wr(3'd3, 8'h40);
    ticks(6);
    read16(3'd1, 1'b0, v);
    check(v == 16'hFFFA, "R6 latched value frozen", v, 16'hFFFA);
    read16(3'd1, 1'b0, v);
    check(v == 16'hFFF7, "R6 live after latched pair", v, 16'hFFF7);
  endtask

  initial begin
    t_reset_state();
    t_load_order();
    t_cascade();
    t_clear_bits();
    t_set_wins();
    t_rate_zero();
    t_strobe_halt();
    t_latch_base();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule